// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the part of a small 16-bit segmented processor core that decides, at each instruction boundary, whether an interrupt is taken, and then performs the entry or return as a series of word transfers on a simple request/acknowledge memory port. The execution unit marks a boundary with a strobe. It can also raise a software interrupt (with its type number) or a return request on that strobe, and it loads the architectural context (flags, code segment, instruction pointer, stack segment, stack pointer) through a write port while the block is idle.

Five sources compete at a boundary. A single-step trap (trap flag set), a qualified non-maskable edge, a latched coprocessor-overrun fault, the maskable request pin (only while the interrupt-enable flag is set) and the software interrupt are considered in that order. Only the first one present is serviced, and the rest wait for a later boundary. Entry saves the flags word, clears the interrupt-enable and trap flags, and saves the code segment and then the instruction pointer on the stack. It then reads the new instruction pointer and code segment from the vector table at four times the type number. A maskable request first runs a one-cycle acknowledge and takes the type number from an 8-bit vector bus. A return reloads the instruction pointer, the code segment and the flags from the stack.

Top module: `irq_entry_seq`

## Requirements
- R1: After synchronous reset the block is idle (busy low), with no memory request, no acknowledge, and flags, code segment, instruction pointer, stack segment and stack pointer all zero.
- R2: At a boundary the sources are ranked trap flag (type 1), non-maskable edge (type 2), coprocessor overrun (type 9), maskable pin, software interrupt (type from the strobe). Only the highest one present is taken. A pending overrun or software interrupt that is not taken is kept for a later boundary, and a boundary with nothing present starts no sequence.
- R3: Entry performs three word writes. Each write goes to physical address stack segment × 16 + stack pointer after the pointer has been lowered by 2. The flags are written first, then the code segment, then the instruction pointer, so the stack pointer ends 6 lower.
- R4: The saved flags word is the value from before entry. After entry the interrupt-enable flag (bit 9) and the trap flag (bit 8) are both 0, and all other flag bits are unchanged.
- R5: After the writes, the new instruction pointer is read from physical address type × 4 and the new code segment from type × 4 + 2. Entry performs exactly five memory transfers.
- R6: The non-maskable pin counts only on a rising edge that follows at least two consecutive clock samples with the pin low. A shorter low does not arm it, and a pin held high does not fire again.
- R7: An armed non-maskable edge whose pin falls before a boundary recognises it is discarded.
- R8: The maskable pin is taken only while the interrupt-enable flag is 1. Taking it raises the acknowledge output for exactly one cycle, and the type number is captured from the vector bus in that cycle.
- R9: A return request at a boundary reads the instruction pointer, the code segment and the flags from stack pointer +0, +2 and +4, and raises the stack pointer by 6. This restores both the interrupt-enable flag and the trap flag.
- R10: Once a transfer is requested, request, address and write data stay unchanged until acknowledged, and each acknowledge completes one transfer.
- R11: Boundary strobes, software requests and context writes that arrive while a sequence is running have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bnd_strobe | input | 1 | Instruction boundary marker |
| ret_req | input | 1 | Return sequence requested with this boundary |
| swi_req | input | 1 | Software interrupt raised with this boundary |
| swi_type | input | 8 | Type number of the software interrupt |
| ctx_wr | input | 1 | Load the context inputs (idle only) |
| ctx_flags | input | 16 | Flags value to load |
| ctx_cs | input | 16 | Code segment to load |
| ctx_ip | input | 16 | Instruction pointer to load |
| ctx_ss | input | 16 | Stack segment to load |
| ctx_sp | input | 16 | Stack pointer to load |
| nmi_pin | input | 1 | Non-maskable request pin |
| cop_ovr | input | 1 | Coprocessor overrun fault pulse |
| intr_pin | input | 1 | Maskable request level |
| inta | output | 1 | Acknowledge pulse for the maskable request |
| vec_data | input | 8 | Vector bus sampled during the acknowledge |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Transfer is a write |
| mem_addr | output | 20 | Physical byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with acknowledge |
| mem_ack | input | 1 | Transfer acknowledge |
| busy | output | 1 | A sequence is running |
| cur_flags | output | 16 | Current flags |
| cur_cs | output | 16 | Current code segment |
| cur_ip | output | 16 | Current instruction pointer |
| cur_sp | output | 16 | Current stack pointer |

## Verification
Properties check the local rules on every cycle: a set trap flag always wins a boundary, the acknowledge never appears with interrupts disabled, both flags are cleared as the flags word is saved, each push lowers and each final pop raises the stack pointer by 2, a stalled transfer keeps its address, and an armed edge vanishes the moment the pin drops or was preceded by too short a low. The scenarios alone can show the whole ordering story. This covers lower sources waiting through several boundaries, the exact stack image and vector-table words, the round trip of entry followed by return, the boundary between one and two low samples, and the absence of any lasting effect from strobes and context writes issued mid-sequence.

// File: rtl/ies_pkg.sv
package ies_pkg;

    localparam int ADDR_W    = 20;
    localparam int WORD_W    = 16;
    localparam int VEC_W     = 8;
    localparam int SEG_SHIFT = 4;

    localparam int FLAG_TF = 8;
    localparam int FLAG_IF = 9;

    // Recognition rank: lower index wins.
    localparam int SRC_STEP = 0;
    localparam int SRC_NMI  = 1;
    localparam int SRC_COP  = 2;
    localparam int SRC_INTR = 3;
    localparam int SRC_SWI  = 4;
    localparam int N_SRC    = 5;

    localparam logic [VEC_W-1:0] VEC_STEP = 8'd1;
    localparam logic [VEC_W-1:0] VEC_NMI  = 8'd2;
    localparam logic [VEC_W-1:0] VEC_COP  = 8'd9;

    localparam logic [WORD_W-1:0] STK_STEP = 16'd2;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ACK,
        S_PUSH_F,
        S_PUSH_CS,
        S_PUSH_IP,
        S_RD_IP,
        S_RD_CS,
        S_POP_IP,
        S_POP_CS,
        S_POP_F
    } seq_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] flags;
        logic [WORD_W-1:0] cs;
        logic [WORD_W-1:0] ip;
        logic [WORD_W-1:0] ss;
        logic [WORD_W-1:0] sp;
    } arch_ctx_t;

    typedef struct packed {
        logic              req;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
    } bus_op_t;

    function automatic logic [ADDR_W-1:0] seg_addr(input logic [WORD_W-1:0] seg,
                                                   input logic [WORD_W-1:0] off);
        logic [ADDR_W-1:0] s;
        logic [ADDR_W-1:0] o;
        s = {{(ADDR_W-WORD_W){1'b0}}, seg};
        o = {{(ADDR_W-WORD_W){1'b0}}, off};
        return (s << SEG_SHIFT) + o;
    endfunction

    function automatic logic [ADDR_W-1:0] vec_addr(input logic [VEC_W-1:0] v,
                                                   input logic             hi);
        return {{(ADDR_W-VEC_W-2){1'b0}}, v, hi, 1'b0};
    endfunction

    function automatic logic is_push(input seq_state_t s);
        return (s == S_PUSH_F) || (s == S_PUSH_CS) || (s == S_PUSH_IP);
    endfunction

endpackage

// File: rtl/ies_nmi_qual.sv
module ies_nmi_qual #(
    parameter int LOW_MIN = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic take,
    output logic ready
);
    localparam int CNT_W = $clog2(LOW_MIN + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LOW_MIN);

    logic [CNT_W-1:0] low_cnt;
    logic             armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
            armed   <= 1'b0;
        end else if (!pin) begin
            if (low_cnt != CNT_MAX) low_cnt <= low_cnt + 1'b1;
            armed <= 1'b0;
        end else begin
            low_cnt <= '0;
            if (take)                  armed <= 1'b0;
            else if (low_cnt == CNT_MAX) armed <= 1'b1;
        end
    end

    assign ready = armed & pin;

    // R7: a fallen pin leaves nothing armed
    assert_drop_discards_R7: assert property (@(posedge clk) disable iff (rst)
        !pin |=> !armed);

    // R6: arming only after a long enough low
    assert_low_qualified_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> ($past(low_cnt) >= CNT_MAX) && $past(pin));

endmodule

// File: rtl/ies_src_pick.sv
module ies_src_pick #(
    parameter int N = 5
) (
    input  logic [N-1:0] pend,
    output logic [N-1:0] grant,
    output logic         any
);
    always_comb begin
        logic seen;
        seen  = 1'b0;
        grant = '0;
        for (int i = 0; i < N; i++) begin
            if (pend[i] && !seen) begin
                grant[i] = 1'b1;
                seen     = 1'b1;
            end
        end
    end

    assign any = |pend;

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import ies_pkg::*;
#(
    parameter int NMI_LOW_MIN = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bnd_strobe,
    input  logic              ret_req,
    input  logic              swi_req,
    input  logic [VEC_W-1:0]  swi_type,
    input  logic              ctx_wr,
    input  logic [WORD_W-1:0] ctx_flags,
    input  logic [WORD_W-1:0] ctx_cs,
    input  logic [WORD_W-1:0] ctx_ip,
    input  logic [WORD_W-1:0] ctx_ss,
    input  logic [WORD_W-1:0] ctx_sp,
    input  logic              nmi_pin,
    input  logic              cop_ovr,
    input  logic              intr_pin,
    output logic              inta,
    input  logic [VEC_W-1:0]  vec_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              busy,
    output logic [WORD_W-1:0] cur_flags,
    output logic [WORD_W-1:0] cur_cs,
    output logic [WORD_W-1:0] cur_ip,
    output logic [WORD_W-1:0] cur_sp
);

    seq_state_t        state;
    arch_ctx_t         ctx;
    logic [VEC_W-1:0]  vec_type;
    logic              cop_pend;
    logic              swi_pend;
    logic [VEC_W-1:0]  swi_type_q;

    logic [N_SRC-1:0]  pend;
    logic [N_SRC-1:0]  grant;
    logic              any_src;
    logic              nmi_ready;
    logic              eval;
    logic [VEC_W-1:0]  pick_type;
    bus_op_t           op;

    // Sources are only looked at on an idle boundary without a return.
    assign eval = (state == S_IDLE) && bnd_strobe && !ret_req;

    always_comb begin
        pend           = '0;
        pend[SRC_STEP] = ctx.flags[FLAG_TF];
        pend[SRC_NMI]  = nmi_ready;
        pend[SRC_COP]  = cop_pend | cop_ovr;
        pend[SRC_INTR] = intr_pin & ctx.flags[FLAG_IF];
        pend[SRC_SWI]  = swi_pend | (bnd_strobe & swi_req);
    end

    ies_src_pick #(.N(N_SRC)) u_pick (
        .pend  (pend),
        .grant (grant),
        .any   (any_src)
    );

    ies_nmi_qual #(.LOW_MIN(NMI_LOW_MIN)) u_nmi (
        .clk   (clk),
        .rst   (rst),
        .pin   (nmi_pin),
        .take  (eval && grant[SRC_NMI]),
        .ready (nmi_ready)
    );

    always_comb begin
        if (grant[SRC_STEP])      pick_type = VEC_STEP;
        else if (grant[SRC_NMI])  pick_type = VEC_NMI;
        else if (grant[SRC_COP])  pick_type = VEC_COP;
        else if (bnd_strobe && swi_req) pick_type = swi_type;
        else                      pick_type = swi_type_q;
    end

    // Memory operation presented in each state.
    always_comb begin
        op = '0;
        unique case (state)
            S_PUSH_F: begin
                op.req = 1'b1; op.we = 1'b1;
                op.addr  = seg_addr(ctx.ss, ctx.sp - STK_STEP);
                op.wdata = ctx.flags;
            end
            S_PUSH_CS: begin
                op.req = 1'b1; op.we = 1'b1;
                op.addr  = seg_addr(ctx.ss, ctx.sp - STK_STEP);
                op.wdata = ctx.cs;
            end
            S_PUSH_IP: begin
                op.req = 1'b1; op.we = 1'b1;
                op.addr  = seg_addr(ctx.ss, ctx.sp - STK_STEP);
                op.wdata = ctx.ip;
            end
            S_RD_IP: begin
                op.req  = 1'b1;
                op.addr = vec_addr(vec_type, 1'b0);
            end
            S_RD_CS: begin
                op.req  = 1'b1;
                op.addr = vec_addr(vec_type, 1'b1);
            end
            S_POP_IP, S_POP_CS, S_POP_F: begin
                op.req  = 1'b1;
                op.addr = seg_addr(ctx.ss, ctx.sp);
            end
            default: op = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            ctx        <= '0;
            vec_type   <= '0;
            cop_pend   <= 1'b0;
            swi_pend   <= 1'b0;
            swi_type_q <= '0;
        end else begin
            if (cop_ovr) cop_pend <= 1'b1;
            unique case (state)
                S_IDLE: begin
                    if (ctx_wr) begin
                        ctx.flags <= ctx_flags;
                        ctx.cs    <= ctx_cs;
                        ctx.ip    <= ctx_ip;
                        ctx.ss    <= ctx_ss;
                        ctx.sp    <= ctx_sp;
                    end
                    if (bnd_strobe && swi_req) begin
                        swi_pend   <= 1'b1;
                        swi_type_q <= swi_type;
                    end
                    if (bnd_strobe && ret_req) begin
                        state <= S_POP_IP;
                    end else if (eval && any_src) begin
                        if (grant[SRC_COP]) cop_pend <= 1'b0;
                        if (grant[SRC_SWI]) swi_pend <= 1'b0;
                        if (grant[SRC_INTR]) begin
                            state <= S_ACK;
                        end else begin
                            state    <= S_PUSH_F;
                            vec_type <= pick_type;
                        end
                    end
                end
                S_ACK: begin
                    vec_type <= vec_data;
                    state    <= S_PUSH_F;
                end
                S_PUSH_F: if (mem_ack) begin
                    ctx.sp             <= ctx.sp - STK_STEP;
                    ctx.flags[FLAG_IF] <= 1'b0;
                    ctx.flags[FLAG_TF] <= 1'b0;
                    state              <= S_PUSH_CS;
                end
                S_PUSH_CS: if (mem_ack) begin
                    ctx.sp <= ctx.sp - STK_STEP;
                    state  <= S_PUSH_IP;
                end
                S_PUSH_IP: if (mem_ack) begin
                    ctx.sp <= ctx.sp - STK_STEP;
                    state  <= S_RD_IP;
                end
                S_RD_IP: if (mem_ack) begin
                    ctx.ip <= mem_rdata;
                    state  <= S_RD_CS;
                end
                S_RD_CS: if (mem_ack) begin
                    ctx.cs <= mem_rdata;
                    state  <= S_IDLE;
                end
                S_POP_IP: if (mem_ack) begin
                    ctx.ip <= mem_rdata;
                    ctx.sp <= ctx.sp + STK_STEP;
                    state  <= S_POP_CS;
                end
                S_POP_CS: if (mem_ack) begin
                    ctx.cs <= mem_rdata;
                    ctx.sp <= ctx.sp + STK_STEP;
                    state  <= S_POP_F;
                end
                S_POP_F: if (mem_ack) begin
                    ctx.flags <= mem_rdata;
                    ctx.sp    <= ctx.sp + STK_STEP;
                    state     <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign mem_req   = op.req;
    assign mem_we    = op.we;
    assign mem_addr  = op.addr;
    assign mem_wdata = op.wdata;
    assign inta      = (state == S_ACK);
    assign busy      = (state != S_IDLE);
    assign cur_flags = ctx.flags;
    assign cur_cs    = ctx.cs;
    assign cur_ip    = ctx.ip;
    assign cur_sp    = ctx.sp;

    // R2: a set trap flag always wins the boundary
    assert_step_first_R2: assert property (@(posedge clk) disable iff (rst)
        (eval && ctx.flags[FLAG_TF]) |=> (state == S_PUSH_F) && (vec_type == VEC_STEP));

    // R8: no acknowledge while interrupts are disabled
    assert_inta_enabled_R8: assert property (@(posedge clk) disable iff (rst)
        inta |-> ctx.flags[FLAG_IF]);

    // R8: a boundary with interrupts disabled never leads to an acknowledge
    assert_masked_no_inta_R8: assert property (@(posedge clk) disable iff (rst)
        (eval && !ctx.flags[FLAG_IF]) |=> !inta);

    // R4: both flags are clear once the flags word is saved
    assert_flags_cleared_R4: assert property (@(posedge clk) disable iff (rst)
        (state == S_PUSH_F && mem_ack) |=> !ctx.flags[FLAG_IF] && !ctx.flags[FLAG_TF]);

    // R3: every completed push lowers the stack pointer by one word
    assert_push_step_R3: assert property (@(posedge clk) disable iff (rst)
        (is_push(state) && mem_ack) |=> ctx.sp == $past(ctx.sp) - STK_STEP);

    // R9: the last pop ends the sequence and raises the pointer
    assert_pop_end_R9: assert property (@(posedge clk) disable iff (rst)
        (state == S_POP_F && mem_ack) |=> (state == S_IDLE) && (ctx.sp == $past(ctx.sp) + STK_STEP));

    // R10: a waiting transfer holds its request and address
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we));

endmodule

// File: tb/test_irq_entry_seq.sv
module test_irq_entry_seq;

    logic        clk = 1'b0;
    logic        rst;
    logic        bnd_strobe, ret_req, swi_req;
    logic [7:0]  swi_type;
    logic        ctx_wr;
    logic [15:0] ctx_flags, ctx_cs, ctx_ip, ctx_ss, ctx_sp;
    logic        nmi_pin, cop_ovr, intr_pin;
    logic        inta;
    logic [7:0]  vec_data;
    logic        mem_req, mem_we, mem_ack;
    logic [19:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;
    logic        busy;
    logic [15:0] cur_flags, cur_cs, cur_ip, cur_sp;

    int n_chk = 0;
    int n_bad = 0;
    int lat = 0;
    int wait_cnt = 0;
    int ack_cnt = 0;
    int inta_cnt = 0;
    int hold_err = 0;

    logic [15:0] mem [0:1023];
    logic        prev_req, prev_ack;
    logic [19:0] prev_addr;

    always #4 clk = ~clk;

    irq_entry_seq i_irq_entry_seq (
        .clk(clk), .rst(rst), .bnd_strobe(bnd_strobe), .ret_req(ret_req),
        .swi_req(swi_req), .swi_type(swi_type), .ctx_wr(ctx_wr),
        .ctx_flags(ctx_flags), .ctx_cs(ctx_cs), .ctx_ip(ctx_ip),
        .ctx_ss(ctx_ss), .ctx_sp(ctx_sp), .nmi_pin(nmi_pin), .cop_ovr(cop_ovr),
        .intr_pin(intr_pin), .inta(inta), .vec_data(vec_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .busy(busy), .cur_flags(cur_flags), .cur_cs(cur_cs), .cur_ip(cur_ip),
        .cur_sp(cur_sp)
    );

    assign mem_rdata = mem[mem_addr[10:1]];

    // Memory model: vector for type n holds offset 0x1000+n and segment 0x2000+n.
    always @(posedge clk) begin
        if (rst) begin
            for (int n = 0; n < 256; n++) begin
                mem[2*n]   <= 16'h1000 + 16'(n);
                mem[2*n+1] <= 16'h2000 + 16'(n);
            end
            mem_ack  <= 1'b0;
            wait_cnt <= 0;
        end else begin
            if (mem_req && mem_ack) begin
                ack_cnt <= ack_cnt + 1;
                if (mem_we) mem[mem_addr[10:1]] <= mem_wdata;
            end
            if (mem_req && !mem_ack) begin
                if (wait_cnt >= lat) begin
                    mem_ack  <= 1'b1;
                    wait_cnt <= 0;
                end else begin
                    wait_cnt <= wait_cnt + 1;
                end
            end else begin
                mem_ack <= 1'b0;
            end
        end
        if (inta) inta_cnt <= inta_cnt + 1;
    end

    always @(negedge clk) begin
        if (rst) begin
            prev_req <= 1'b0;
            prev_ack <= 1'b0;
            prev_addr <= '0;
        end else begin
            if (prev_req && !prev_ack && (!mem_req || mem_addr != prev_addr)) hold_err <= hold_err + 1;
            prev_req  <= mem_req;
            prev_ack  <= mem_ack;
            prev_addr <= mem_addr;
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic set_ctx(input logic [15:0] f, input logic [15:0] c, input logic [15:0] i,
                           input logic [15:0] s, input logic [15:0] p);
        ctx_wr = 1'b1; ctx_flags = f; ctx_cs = c; ctx_ip = i; ctx_ss = s; ctx_sp = p;
        @(negedge clk);
        ctx_wr = 1'b0;
    endtask

    task automatic boundary(input logic r, input logic s, input logic [7:0] t);
        bnd_strobe = 1'b1; ret_req = r; swi_req = s; swi_type = t;
        @(negedge clk);
        bnd_strobe = 1'b0; ret_req = 1'b0; swi_req = 1'b0;
        while (busy) @(negedge clk);
    endtask

    task automatic pulse_cop();
        cop_ovr = 1'b1;
        @(negedge clk);
        cop_ovr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 mem_req", 32'(mem_req), 32'd0);
        chk("R1 inta", 32'(inta), 32'd0);
        chk("R1 flags", 32'(cur_flags), 32'h0);
        chk("R1 ip/cs", {cur_ip, cur_cs}, 32'h0);
        chk("R1 sp", 32'(cur_sp), 32'h0);
    endtask

    task automatic t_swi_entry();
        int a0;
        set_ctx(16'h0045, 16'h1111, 16'h2222, 16'h0010, 16'h0500);
        a0 = ack_cnt;
        boundary(1'b0, 1'b1, 8'h41);
        chk("R3 saved flags", 32'(mem[10'h2FF]), 32'h0045);
        chk("R3 saved cs", 32'(mem[10'h2FE]), 32'h1111);
        chk("R3 saved ip", 32'(mem[10'h2FD]), 32'h2222);
        chk("R3 sp", 32'(cur_sp), 32'h04FA);
        chk("R5 new ip", 32'(cur_ip), 32'h1041);
        chk("R5 new cs", 32'(cur_cs), 32'h2041);
        chk("R5 transfers", 32'(ack_cnt - a0), 32'd5);
    endtask

    task automatic t_order();
        int i0;
        set_ctx(16'h0345, 16'h0A0A, 16'h0B0B, 16'h0000, 16'h0600);
        intr_pin = 1'b1;
        pulse_cop();
        boundary(1'b0, 1'b1, 8'h42);
        chk("R2 step first", 32'(cur_ip), 32'h1001);
        chk("R4 saved flags", 32'(mem[10'h2FF]), 32'h0345);
        chk("R4 flags after", 32'(cur_flags), 32'h0045);
        boundary(1'b0, 1'b0, 8'h00);
        chk("R2 overrun next", 32'(cur_ip), 32'h1009);
        boundary(1'b0, 1'b0, 8'h00);
        chk("R2 software kept", 32'(cur_ip), 32'h1042);
        boundary(1'b0, 1'b0, 8'h00);
        chk("R8 masked pin ignored", {15'd0, busy, cur_ip}, 32'h0000_1042);
        set_ctx(16'h0200, 16'h0A0A, 16'h0B0B, 16'h0000, 16'h0600);
        i0 = inta_cnt;
        boundary(1'b0, 1'b0, 8'h00);
        chk("R8 vector from bus", 32'(cur_ip), 32'h1020);
        chk("R8 one acknowledge", 32'(inta_cnt - i0), 32'd1);
        chk("R4 IF cleared", 32'(cur_flags), 32'h0000);
        intr_pin = 1'b0;
    endtask

    task automatic t_nmi();
        set_ctx(16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0600);
        pulse_cop();
        nmi_pin = 1'b1;
        repeat (2) @(negedge clk);
        boundary(1'b0, 1'b0, 8'h00);
        chk("R2 nmi over overrun", 32'(cur_ip), 32'h1002);
        boundary(1'b0, 1'b0, 8'h00);
        chk("R2 overrun after nmi", 32'(cur_ip), 32'h1009);
        boundary(1'b0, 1'b0, 8'h00);
        chk("R6 held high no refire", 32'(cur_ip), 32'h1009);
        nmi_pin = 1'b0;
        @(negedge clk);
        nmi_pin = 1'b1;
        repeat (2) @(negedge clk);
        boundary(1'b0, 1'b0, 8'h00);
        chk("R6 one low sample", 32'(cur_ip), 32'h1009);
        nmi_pin = 1'b0;
        repeat (2) @(negedge clk);
        nmi_pin = 1'b1;
        repeat (2) @(negedge clk);
        boundary(1'b0, 1'b0, 8'h00);
        chk("R6 two low samples", 32'(cur_ip), 32'h1002);
        set_ctx(16'h0000, 16'h0000, 16'h5555, 16'h0000, 16'h0600);
        nmi_pin = 1'b0;
        repeat (3) @(negedge clk);
        nmi_pin = 1'b1;
        repeat (2) @(negedge clk);
        nmi_pin = 1'b0;
        @(negedge clk);
        boundary(1'b0, 1'b0, 8'h00);
        chk("R7 dropped edge", {15'd0, busy, cur_ip}, 32'h0000_5555);
    endtask

    task automatic t_return();
        set_ctx(16'h0301, 16'h4444, 16'h3333, 16'h0000, 16'h0600);
        boundary(1'b0, 1'b0, 8'h00);
        chk("R4 trap entry flags", 32'(cur_flags), 32'h0001);
        boundary(1'b1, 1'b0, 8'h00);
        chk("R9 ip restored", 32'(cur_ip), 32'h3333);
        chk("R9 cs restored", 32'(cur_cs), 32'h4444);
        chk("R9 flags restored", 32'(cur_flags), 32'h0301);
        chk("R9 sp restored", 32'(cur_sp), 32'h0600);
        set_ctx(16'h0000, 16'h4444, 16'h3333, 16'h0000, 16'h0600);
    endtask

    task automatic t_busy();
        lat = 4;
        set_ctx(16'h0000, 16'h7777, 16'h8888, 16'h0000, 16'h0600);
        bnd_strobe = 1'b1; swi_req = 1'b1; swi_type = 8'h41;
        @(negedge clk);
        bnd_strobe = 1'b0; swi_req = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 busy mid entry", 32'(busy), 32'd1);
        bnd_strobe = 1'b1; swi_req = 1'b1; swi_type = 8'h42;
        ctx_wr = 1'b1; ctx_flags = 16'h0300; ctx_ip = 16'hDEAD; ctx_sp = 16'h0100;
        @(negedge clk);
        bnd_strobe = 1'b0; swi_req = 1'b0; ctx_wr = 1'b0;
        while (busy) @(negedge clk);
        chk("R11 ip from first", 32'(cur_ip), 32'h1041);
        chk("R11 sp untouched", 32'(cur_sp), 32'h05FA);
        chk("R11 flags untouched", 32'(cur_flags), 32'h0000);
        chk("R11 saved ip", 32'(mem[10'h2FD]), 32'h8888);
        boundary(1'b0, 1'b0, 8'h00);
        chk("R11 late strobe not kept", 32'(cur_ip), 32'h1041);
        lat = 0;
        chk("R10 held while waiting", 32'(hold_err), 32'd0);
    endtask

    initial begin
        rst = 1'b1;
        bnd_strobe = 1'b0; ret_req = 1'b0; swi_req = 1'b0; swi_type = '0;
        ctx_wr = 1'b0; ctx_flags = '0; ctx_cs = '0; ctx_ip = '0; ctx_ss = '0; ctx_sp = '0;
        nmi_pin = 1'b0; cop_ovr = 1'b0; intr_pin = 1'b0; vec_data = 8'h20;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_swi_entry();
        t_order();
        t_nmi();
        t_return();
        t_busy();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R10 watchdog: actual hang expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule